// File: doc/BRIEF.md
# Low-Power Mode and Clock Gating Controller

This block sits next to a small processor core and decides which clocks run. A one-cycle power-save request, taken together with a one-bit mode operand, moves the controller from normal execution into one of two reduced-power states. The first is a deep state that shuts off the system clock source and every clock derived from it. The second is a light state that halts only the CPU and lets each peripheral choose, through its own stop bit, whether its clock stays on. Enabled interrupts, reset events and watchdog timeouts bring the controller back to normal execution. On entry to either state the controller sends the watchdog a one-cycle clear pulse.

In normal execution the controller can also slow the CPU while peripherals keep their full rate. In this throttled mode, the CPU clock enable becomes a one-cycle strobe every 2^n system clocks. Because the strobe is derived from the same system clock that drives the peripherals, every CPU step lines up with a peripheral clock edge. The block also drives the enable of the low-power oscillator and the enable of the clock monitor. The oscillators, the watchdog counter and the interrupt controller are outside this block.

All pins are plain level or pulse controls. There is no data stream, so no valid/ready handshake exists. All requests are sampled on the rising edge of `clk`.

Top module: `pgc_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the controller is in run: `cpu_clk_en`=1 (with `doze_en`=0), `sysclk_src_en`=1, all `periph_clk_en` bits 1, `wdt_clr`=0, `wake`=0.
- R2: In run, if `sav_req`=1, `sav_mode`=0 and `rst_evt`=0 are sampled at an edge, the controller enters sleep at that edge. In sleep, `cpu_clk_en`, `sysclk_src_en`, `clkmon_active` and every `periph_clk_en` bit are 0.
- R3: The same request with `sav_mode`=1 enters idle. In idle, `cpu_clk_en`=0 and `sysclk_src_en`=1, and `periph_clk_en[i]` equals the inverse of `stop_in_idle[i]`, following that input combinationally.
- R4: `wdt_clr` is high for exactly the first cycle of sleep or idle and is low in every other cycle.
- R5: `lpo_en` equals `wdt_en`|`clkmon_en` in run and idle, and equals `wdt_en` in sleep. `clkmon_active` equals `clkmon_en` except in sleep, where it is 0.
- R6: In sleep or idle, any of `irq_wake`, `rst_evt` or `wdt_timeout` sampled high at an edge returns the controller to run at that edge. `wake` is high for exactly that first run cycle, and `cpu_clk_en` is 1 in that cycle.
- R7: `sav_req` sampled while in sleep or idle has no effect. The state, the clock enables and `wdt_clr` are unchanged.
- R8: `rst_evt` takes priority. In run, `sav_req` sampled together with `rst_evt` is dropped: the controller stays in run and `wdt_clr` stays 0.
- R9: In run with `doze_en`=1 and `doze_ratio`=n (code n means 1:2^n, n=0..7), `cpu_clk_en` is high for one cycle out of every 2^n.
- R10: The strobe phase restarts after the edge at which `doze_en` is 0, `doze_ratio` differs from its value at the previous edge, or a wake occurs. The cycle after that edge carries a strobe. In the cycle in which `doze_ratio` first shows a new value, the strobe is unspecified.
- R11: In run, `cpu_clk_en` is 1 in every cycle when `doze_en`=0 or `doze_ratio`=0.
- R12: In run, every `periph_clk_en` bit is 1, regardless of the throttled mode and of `stop_in_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sav_req | input | 1 | Power-save request pulse |
| sav_mode | input | 1 | Request operand: 0 sleep, 1 idle |
| rst_evt | input | 1 | Device reset event (wake source, highest priority) |
| irq_wake | input | 1 | Any individually enabled interrupt pending |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wdt_en | input | 1 | Watchdog enabled |
| clkmon_en | input | 1 | Clock monitor enabled |
| doze_en | input | 1 | Throttle CPU relative to peripherals |
| doze_ratio | input | RATIO_W | Throttle code n, ratio 1:2^n |
| stop_in_idle | input | N_PERIPH | Per-peripheral stop bit for idle |
| cpu_clk_en | output | 1 | CPU clock enable / strobe |
| sysclk_src_en | output | 1 | System clock source enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enable |
| lpo_en | output | 1 | Low-power oscillator enable |
| clkmon_active | output | 1 | Clock monitor enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wake | output | 1 | Wake indication pulse |

## Verification
On every cycle, the assertions check that the port outputs stay consistent with each other. When the system clock is off, the CPU, the peripherals and the clock monitor are off too, and the oscillator follows the watchdog enable. A CPU strobe implies that all peripherals run. Each clear or wake pulse follows a matching cause from the previous edge, and a wake pulse always comes with a CPU enable. Only the bench's scenarios can show the behaviour that depends on history. That covers the exact strobe period for each ratio code, the phase restart after ratio changes and wakes, the reset priority over a simultaneous request, and requests that are dropped while the controller is already in a low-power state.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_state_e;

  localparam logic MODE_SLEEP = 1'b0;
  localparam logic MODE_IDLE  = 1'b1;
endpackage

// File: rtl/pgc_mode_fsm.sv
module pgc_mode_fsm
  import pgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sav_req,
  input  logic      sav_mode,
  input  logic      rst_evt,
  input  logic      irq_wake,
  input  logic      wdt_timeout,
  output pm_state_e state,
  output logic      exit_evt,
  output logic      wdt_clr,
  output logic      wake
);
  pm_state_e state_nxt;
  logic      low_pwr;
  logic      enter_evt;

  always_comb begin
    low_pwr   = (state != PM_RUN);
    // reset events win over everything; any listed source ends a low-power stay
    exit_evt  = low_pwr && (rst_evt || irq_wake || wdt_timeout);
    enter_evt = !low_pwr && sav_req && !rst_evt;
    state_nxt = state;
    if (exit_evt) begin
      state_nxt = PM_RUN;
    end else if (enter_evt) begin
      state_nxt = (sav_mode == MODE_IDLE) ? PM_IDLE : PM_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PM_RUN;
      wdt_clr <= 1'b0;
      wake    <= 1'b0;
    end else begin
      state   <= state_nxt;
      wdt_clr <= enter_evt;
      wake    <= exit_evt;
    end
  end
endmodule

// File: rtl/pgc_doze_gen.sv
module pgc_doze_gen #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               doze_en,
  input  logic [RATIO_W-1:0] doze_ratio,
  input  logic               restart,
  output logic               strobe
);
  localparam int CNT_W = (2 ** RATIO_W) - 1;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   mask;
  logic [RATIO_W-1:0] ratio_q;
  logic               resync;

  // mask holds the low n bits for ratio code n
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(doze_ratio));
    end
  end

  assign resync = !doze_en || (doze_ratio != ratio_q) || restart;
  assign strobe = !doze_en || ((cnt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= '0;
    end else begin
      ratio_q <= doze_ratio;
      if (resync) begin
        cnt <= '0;
      end else begin
        cnt <= (cnt + CNT_W'(1)) & mask;
      end
    end
  end
endmodule

// File: rtl/pgc_clk_gate.sv
module pgc_clk_gate
  import pgc_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  pm_state_e           state,
  input  logic                doze_strobe,
  input  logic [N_PERIPH-1:0] stop_in_idle,
  input  logic                wdt_en,
  input  logic                clkmon_en,
  output logic                cpu_clk_en,
  output logic                sysclk_src_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                lpo_en,
  output logic                clkmon_active
);
  logic in_run, in_idle, in_sleep;

  assign in_run   = (state == PM_RUN);
  assign in_idle  = (state == PM_IDLE);
  assign in_sleep = (state == PM_SLEEP);

  assign cpu_clk_en    = in_run && doze_strobe;
  assign sysclk_src_en = !in_sleep;
  assign clkmon_active = clkmon_en && !in_sleep;
  assign lpo_en        = wdt_en || (clkmon_en && !in_sleep);

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
    assign periph_clk_en[p] = in_run || (in_idle && !stop_in_idle[p]);
  end
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int RATIO_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sav_req,
  input  logic                sav_mode,
  input  logic                rst_evt,
  input  logic                irq_wake,
  input  logic                wdt_timeout,
  input  logic                wdt_en,
  input  logic                clkmon_en,
  input  logic                doze_en,
  input  logic [RATIO_W-1:0]  doze_ratio,
  input  logic [N_PERIPH-1:0] stop_in_idle,
  output logic                cpu_clk_en,
  output logic                sysclk_src_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                lpo_en,
  output logic                clkmon_active,
  output logic                wdt_clr,
  output logic                wake
);
  pm_state_e state;
  logic      exit_evt;
  logic      doze_strobe;

  pgc_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sav_req     (sav_req),
    .sav_mode    (sav_mode),
    .rst_evt     (rst_evt),
    .irq_wake    (irq_wake),
    .wdt_timeout (wdt_timeout),
    .state       (state),
    .exit_evt    (exit_evt),
    .wdt_clr     (wdt_clr),
    .wake        (wake)
  );

  pgc_doze_gen #(.RATIO_W(RATIO_W)) u_doze (
    .clk        (clk),
    .rst_n      (rst_n),
    .doze_en    (doze_en),
    .doze_ratio (doze_ratio),
    .restart    (exit_evt),
    .strobe     (doze_strobe)
  );

  pgc_clk_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .state         (state),
    .doze_strobe   (doze_strobe),
    .stop_in_idle  (stop_in_idle),
    .wdt_en        (wdt_en),
    .clkmon_en     (clkmon_en),
    .cpu_clk_en    (cpu_clk_en),
    .sysclk_src_en (sysclk_src_en),
    .periph_clk_en (periph_clk_en),
    .lpo_en        (lpo_en),
    .clkmon_active (clkmon_active)
  );
endmodule

// File: rtl/pgc_checks.sv
module pgc_checks #(
  parameter int N_PERIPH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sav_req,
  input logic                rst_evt,
  input logic                irq_wake,
  input logic                wdt_timeout,
  input logic                wdt_en,
  input logic                cpu_clk_en,
  input logic                sysclk_src_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic                lpo_en,
  input logic                clkmon_active,
  input logic                wdt_clr,
  input logic                wake
);
  assert_sleep_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_src_en |-> (!cpu_clk_en && (periph_clk_en == '0) && !clkmon_active));

  assert_sleep_lpo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_src_en |-> (lpo_en == wdt_en));

  assert_clr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> ($past(sav_req) && !$past(rst_evt) && !cpu_clk_en));

  assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(irq_wake) || $past(rst_evt) || $past(wdt_timeout)));

  assert_wake_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (cpu_clk_en && !wdt_clr));

  assert_run_periph_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (&periph_clk_en && sysclk_src_en));
endmodule

bind pgc_top pgc_checks #(.N_PERIPH(N_PERIPH)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .sav_req       (sav_req),
  .rst_evt       (rst_evt),
  .irq_wake      (irq_wake),
  .wdt_timeout   (wdt_timeout),
  .wdt_en        (wdt_en),
  .cpu_clk_en    (cpu_clk_en),
  .sysclk_src_en (sysclk_src_en),
  .periph_clk_en (periph_clk_en),
  .lpo_en        (lpo_en),
  .clkmon_active (clkmon_active),
  .wdt_clr       (wdt_clr),
  .wake          (wake)
);

// File: tb/tb_pgc_top.sv
`timescale 1ns/1ps
module tb_pgc_top;
  localparam int NP = 8;
  localparam int RW = 3;
  localparam int S_RUN = 0, S_IDLE = 1, S_SLEEP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sav_req = 0, sav_mode = 0, rst_evt = 0, irq_wake = 0, wdt_timeout = 0;
  logic wdt_en = 0, clkmon_en = 0, doze_en = 0;
  logic [RW-1:0] doze_ratio = '0;
  logic [NP-1:0] stop_in_idle = '0;
  logic cpu_clk_en, sysclk_src_en, lpo_en, clkmon_active, wdt_clr, wake;
  logic [NP-1:0] periph_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_state = S_RUN;
  int m_phase = 0;
  int m_ratio = 0;
  bit m_clr = 0;
  bit m_wake = 0;

  always #4 clk = ~clk;

  pgc_top #(.N_PERIPH(NP), .RATIO_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .sav_req(sav_req), .sav_mode(sav_mode),
    .rst_evt(rst_evt), .irq_wake(irq_wake), .wdt_timeout(wdt_timeout),
    .wdt_en(wdt_en), .clkmon_en(clkmon_en), .doze_en(doze_en),
    .doze_ratio(doze_ratio), .stop_in_idle(stop_in_idle),
    .cpu_clk_en(cpu_clk_en), .sysclk_src_en(sysclk_src_en),
    .periph_clk_en(periph_clk_en), .lpo_en(lpo_en),
    .clkmon_active(clkmon_active), .wdt_clr(wdt_clr), .wake(wake)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] exp_periph();
    if (m_state == S_RUN) return '1;
    if (m_state == S_IDLE) return ~stop_in_idle;
    return '0;
  endfunction

  function automatic bit exp_cpu();
    if (m_state != S_RUN) return 1'b0;
    if (!doze_en) return 1'b1;
    return (m_phase % (1 << int'(doze_ratio))) == 0;
  endfunction

  function automatic bit exp_lpo();
    if (m_state == S_SLEEP) return wdt_en;
    return wdt_en | clkmon_en;
  endfunction

  // compare outputs to the model, then advance the model at the next edge
  task automatic step();
    string ctag;
    #1;
    if (m_state == S_RUN) begin
      if (!doze_en || doze_ratio == 0) ctag = "R11";
      else if (m_phase == 0) ctag = "R10";
      else ctag = "R9";
      if (!(doze_en && int'(doze_ratio) != m_ratio))
        chk(cpu_clk_en == exp_cpu(), ctag, 32'(cpu_clk_en), 32'(exp_cpu()));
      chk(periph_clk_en == exp_periph(), "R12", 32'(periph_clk_en), 32'(exp_periph()));
    end else begin
      chk(cpu_clk_en == 1'b0, (m_state == S_IDLE) ? "R3" : "R2", 32'(cpu_clk_en), 0);
      chk(periph_clk_en == exp_periph(), (m_state == S_IDLE) ? "R3" : "R2",
          32'(periph_clk_en), 32'(exp_periph()));
    end
    chk(sysclk_src_en == (m_state != S_SLEEP), "R2", 32'(sysclk_src_en), 32'(m_state != S_SLEEP));
    chk(lpo_en == exp_lpo(), "R5", 32'(lpo_en), 32'(exp_lpo()));
    chk(clkmon_active == (clkmon_en && m_state != S_SLEEP), "R5", 32'(clkmon_active),
        32'(clkmon_en && m_state != S_SLEEP));
    chk(wdt_clr == m_clr, "R4", 32'(wdt_clr), 32'(m_clr));
    chk(wake == m_wake, "R6", 32'(wake), 32'(m_wake));
    @(posedge clk);
    begin
      bit lowp, ex, en, sync;
      lowp = (m_state != S_RUN);
      ex   = lowp && (rst_evt || irq_wake || wdt_timeout);
      en   = !lowp && sav_req && !rst_evt;
      sync = !doze_en || (int'(doze_ratio) != m_ratio) || ex;
      m_phase = sync ? 0 : m_phase + 1;
      m_ratio = int'(doze_ratio);
      m_clr   = en;
      m_wake  = ex;
      if (ex) m_state = S_RUN;
      else if (en) m_state = sav_mode ? S_IDLE : S_SLEEP;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    sav_req = 0; rst_evt = 0; irq_wake = 0; wdt_timeout = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    #1;
    chk(cpu_clk_en && sysclk_src_en && (&periph_clk_en), "R1 in reset",
        32'({cpu_clk_en, sysclk_src_en, &periph_clk_en}), 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!wdt_clr && !wake && cpu_clk_en, "R1 after release",
        32'({wdt_clr, wake, cpu_clk_en}), 32'h1);
    step();

    // sleep entry with watchdog on, then wake by interrupt
    wdt_en = 1; clkmon_en = 1;
    sav_req = 1; sav_mode = 0; step(); quiet();
    step(); step();
    sav_req = 1; sav_mode = 1; step(); sav_req = 0;   // R7: request in sleep ignored
    #1;
    chk(!sysclk_src_en && !wdt_clr, "R7 request in sleep", 32'({sysclk_src_en, wdt_clr}), 0);
    irq_wake = 1; step(); quiet();
    step();

    // idle entry with stop bits, wake by timeout
    stop_in_idle = 8'hA5;
    sav_req = 1; sav_mode = 1; step(); quiet();
    stop_in_idle = 8'h0F; step();
    sav_req = 1; sav_mode = 0; step(); sav_req = 0;
    #1;
    chk(sysclk_src_en && !wdt_clr, "R7 request in idle", 32'({sysclk_src_en, wdt_clr}), 32'h2);
    wdt_timeout = 1; step(); quiet();
    step();

    // reset priority against a same-cycle request
    sav_req = 1; sav_mode = 0; rst_evt = 1; step(); quiet();
    #1;
    chk(sysclk_src_en && cpu_clk_en && !wdt_clr, "R8 reset wins",
        32'({sysclk_src_en, cpu_clk_en, wdt_clr}), 32'h6);
    step();

    // doze ratio 3 directed: one strobe per 8 cycles
    doze_en = 1; doze_ratio = 3'd3;
    for (int i = 0; i < 40; i++) step();
    doze_ratio = 3'd7;
    for (int i = 0; i < 300; i++) step();
    doze_ratio = 3'd0;
    for (int i = 0; i < 10; i++) step();
    // wake restarts phase
    doze_ratio = 3'd2; step(); step();
    sav_req = 1; sav_mode = 1; step(); quiet();
    step();
    rst_evt = 1; step(); quiet();
    for (int i = 0; i < 12; i++) step();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      sav_req     = ($urandom % 4) == 0;
      sav_mode    = $urandom % 2;
      rst_evt     = ($urandom % 24) == 0;
      irq_wake    = ($urandom % 10) == 0;
      wdt_timeout = ($urandom % 30) == 0;
      if (($urandom % 40) == 0) doze_en = ~doze_en;
      if (($urandom % 70) == 0) doze_ratio = RW'($urandom);
      if (($urandom % 16) == 0) stop_in_idle = NP'($urandom);
      if (($urandom % 50) == 0) wdt_en = ~wdt_en;
      if (($urandom % 50) == 0) clkmon_en = ~clkmon_en;
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule